// File: doc/BRIEF.md
# Keyed Sprite Row Blitter

This block copies a linear run of byte pixels from a source region to a destination region, and is mostly used to paint one row of a sprite into a frame buffer. The source and the destination are each selected as main memory or video memory, in any of the four combinations. Before starting a copy, software-facing logic presents a source address, a destination address, a length, a transparent key and the two region selects, then pulses start. A pixel whose value equals the key is not written, so the destination byte under it keeps its old value.

The blitter shares a memory time slot with one processor and runs on that processor's clock. It may drive a main-memory cycle only while `slot_free` is high, which means the processor is executing out of its private memory. Video-memory cycles do not depend on `slot_free`. Each source read returns two adjacent pixels in one cycle, and two write cycles follow it, so the copy runs at three clocks per pixel pair. When the slot is withdrawn in the middle of a copy, the engine stalls with every address and count held, and it continues once the slot comes back.

The controller has four states. ST_IDLE waits for start and latches the command. It goes to ST_FETCH when the length is non-zero, and stays in ST_IDLE with a done pulse when the length is zero. ST_FETCH reads a pixel pair and moves to ST_PUT_LO. ST_PUT_LO handles the lower pixel and goes to ST_PUT_HI, or to ST_IDLE if that pixel was the last one. ST_PUT_HI handles the upper pixel and goes back to ST_FETCH, or to ST_IDLE after the last pixel. Any of the three working states holds in place while its access is blocked.

Top module: `row_blitter`

## Requirements
- R1: After reset, busy, done and mem_req are all low.
- R2: A start pulse seen while idle latches the source, destination, length, key and both region selects (0 = main, 1 = video) and raises busy in the next cycle. A source read asserts mem_req with mem_we low. It returns the pixel at mem_addr in mem_rdata[7:0] and the pixel at mem_addr+1 in mem_rdata[15:8], and each successive read address is 2 higher than the one before.
- R3: Destination writes (mem_req with mem_we high) carry the source pixels in source order, to destination addresses that rise by one per pixel, in the destination region.
- R4: A pixel equal to the latched key is never written. It still uses its write cycle, with mem_req low, and the destination byte keeps its old value.
- R5: While nothing blocks it, a job of N pixels keeps busy high for 3*(N/2) + 2*(N mod 2) cycles.
- R6: A main-memory access (mem_region = 0) is issued only in a cycle where slot_free is high. Video accesses and skipped pixels go ahead whatever the value of slot_free.
- R7: When an access is blocked, the engine holds its address, its direction and its count, and it resumes with no pixel lost or repeated.
- R8: done is high for exactly one cycle, and it is high in the first cycle in which busy is low after a job.
- R9: A start with length zero gives done in the next cycle, with no memory access and no busy cycle.
- R10: A start pulse while busy is ignored. The running job's writes are unchanged and no further job follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the paired processor |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse, taken only when idle |
| cmd_src | input | 16 | First source byte address |
| cmd_src_vid | input | 1 | Source region: 0 main, 1 video |
| cmd_dst | input | 16 | First destination byte address |
| cmd_dst_vid | input | 1 | Destination region: 0 main, 1 video |
| cmd_len | input | 8 | Number of pixels to copy |
| cmd_key | input | 8 | Transparent pixel value |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| slot_free | input | 1 | Main memory may be used in this cycle |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = write, 0 = read of a pixel pair |
| mem_region | output | 1 | 0 main, 1 video |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Pixel to write |
| mem_rdata | input | 16 | Pixel pair returned in the same cycle |

## Verification
The hardest case to reach from the ports is a slot withdrawal that lands on each working state in turn: on a pair fetch, on the lower write, on the upper write, and on a cycle whose pixel is transparent and so does not need the slot at all. The bench gets there by driving slot_free from a shift-register pattern during a main-to-main copy whose key matches some of the pixels. Every write is then compared in order against a queue of expected writes. The bench also runs a video-to-video copy with slot_free held low, to show that those accesses never wait.

// File: rtl/blit_pkg.sv
package blit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_PUT_LO = 2'd2,
        ST_PUT_HI = 2'd3
    } blit_state_e;

    localparam logic REGION_MAIN  = 1'b0;
    localparam logic REGION_VIDEO = 1'b1;

endpackage

// File: rtl/blit_cursor.sv
module blit_cursor #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int PIX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] src_in,
    input  logic              src_vid_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic              dst_vid_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [PIX_W-1:0]  key_in,
    input  logic              adv_src,
    input  logic              adv_dst,
    output logic [ADDR_W-1:0] src_addr,
    output logic              src_vid,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              dst_vid,
    output logic [PIX_W-1:0]  key,
    output logic              last_px
);
    localparam logic [ADDR_W-1:0] PAIR_STEP = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] BYTE_STEP = ADDR_W'(1);
    localparam logic [LEN_W-1:0]  ONE_LEFT  = LEN_W'(1);

    logic [LEN_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_addr <= '0;
            dst_addr <= '0;
            src_vid  <= 1'b0;
            dst_vid  <= 1'b0;
            key      <= '0;
            left_q   <= '0;
        end else if (load) begin
            src_addr <= src_in;
            dst_addr <= dst_in;
            src_vid  <= src_vid_in;
            dst_vid  <= dst_vid_in;
            key      <= key_in;
            left_q   <= len_in;
        end else begin
            if (adv_src) begin
                src_addr <= src_addr + PAIR_STEP;
            end
            if (adv_dst) begin
                dst_addr <= dst_addr + BYTE_STEP;
                left_q   <= left_q - ONE_LEFT;
            end
        end
    end

    assign last_px = (left_q == ONE_LEFT);

endmodule

// File: rtl/blit_pixel.sv
module blit_pixel #(
    parameter int PIX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [2*PIX_W-1:0] rdata,
    input  logic               sel_hi,
    input  logic [PIX_W-1:0]   key,
    output logic [PIX_W-1:0]   pixel,
    output logic               transparent
);
    logic [2*PIX_W-1:0] pair_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q <= '0;
        end else if (capture) begin
            pair_q <= rdata;
        end
    end

    always_comb begin
        pixel       = sel_hi ? pair_q[2*PIX_W-1:PIX_W] : pair_q[PIX_W-1:0];
        transparent = (pixel == key);
    end

endmodule

// File: rtl/blit_fsm.sv
module blit_fsm
    import blit_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        len_zero,
    input  logic        slot_free,
    input  logic        src_vid,
    input  logic        dst_vid,
    input  logic        transparent,
    input  logic        last_px,
    output blit_state_e state,
    output logic        load,
    output logic        capture,
    output logic        adv_src,
    output logic        adv_dst,
    output logic        sel_hi,
    output logic        req,
    output logic        we,
    output logic        stall,
    output logic        busy,
    output logic        done
);
    blit_state_e next_state;
    logic        done_d;
    logic        src_ok;
    logic        dst_ok;
    logic        put_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= next_state;
            done  <= done_d;
        end
    end

    always_comb begin
        src_ok     = src_vid | slot_free;
        dst_ok     = dst_vid | slot_free;
        put_ok     = transparent | dst_ok;
        next_state = state;
        done_d     = 1'b0;
        load       = 1'b0;
        capture    = 1'b0;
        adv_src    = 1'b0;
        adv_dst    = 1'b0;
        sel_hi     = 1'b0;
        req        = 1'b0;
        we         = 1'b0;
        stall      = 1'b0;
        busy       = (state != ST_IDLE);
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (len_zero) begin
                        done_d = 1'b1;
                    end else begin
                        next_state = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                req   = src_ok;
                stall = !src_ok;
                if (src_ok) begin
                    capture    = 1'b1;
                    adv_src    = 1'b1;
                    next_state = ST_PUT_LO;
                end
            end
            ST_PUT_LO, ST_PUT_HI: begin
                sel_hi = (state == ST_PUT_HI);
                we     = 1'b1;
                req    = !transparent && dst_ok;
                stall  = !put_ok;
                if (put_ok) begin
                    adv_dst = 1'b1;
                    if (last_px) begin
                        next_state = ST_IDLE;
                        done_d     = 1'b1;
                    end else if (state == ST_PUT_LO) begin
                        next_state = ST_PUT_HI;
                    end else begin
                        next_state = ST_FETCH;
                    end
                end
            end
            default: begin
                next_state = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/row_blitter.sv
module row_blitter
    import blit_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int PIX_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic [ADDR_W-1:0]  cmd_src,
    input  logic               cmd_src_vid,
    input  logic [ADDR_W-1:0]  cmd_dst,
    input  logic               cmd_dst_vid,
    input  logic [LEN_W-1:0]   cmd_len,
    input  logic [PIX_W-1:0]   cmd_key,
    output logic               busy,
    output logic               done,
    input  logic               slot_free,
    output logic               mem_req,
    output logic               mem_we,
    output logic               mem_region,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [PIX_W-1:0]   mem_wdata,
    input  logic [2*PIX_W-1:0] mem_rdata
);
    blit_state_e       state;
    logic              load_w;
    logic              capture_w;
    logic              adv_src_w;
    logic              adv_dst_w;
    logic              sel_hi_w;
    logic              stall_w;
    logic              last_px_w;
    logic              transparent_w;
    logic              src_vid_q;
    logic              dst_vid_q;
    logic [ADDR_W-1:0] src_addr_q;
    logic [ADDR_W-1:0] dst_addr_q;
    logic [PIX_W-1:0]  key_q;
    logic [PIX_W-1:0]  pixel_w;

    blit_cursor #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .PIX_W  (PIX_W)
    ) cursor_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_w),
        .src_in     (cmd_src),
        .src_vid_in (cmd_src_vid),
        .dst_in     (cmd_dst),
        .dst_vid_in (cmd_dst_vid),
        .len_in     (cmd_len),
        .key_in     (cmd_key),
        .adv_src    (adv_src_w),
        .adv_dst    (adv_dst_w),
        .src_addr   (src_addr_q),
        .src_vid    (src_vid_q),
        .dst_addr   (dst_addr_q),
        .dst_vid    (dst_vid_q),
        .key        (key_q),
        .last_px    (last_px_w)
    );

    blit_pixel #(
        .PIX_W (PIX_W)
    ) pixel_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture_w),
        .rdata       (mem_rdata),
        .sel_hi      (sel_hi_w),
        .key         (key_q),
        .pixel       (pixel_w),
        .transparent (transparent_w)
    );

    blit_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (cmd_start),
        .len_zero    (cmd_len == '0),
        .slot_free   (slot_free),
        .src_vid     (src_vid_q),
        .dst_vid     (dst_vid_q),
        .transparent (transparent_w),
        .last_px     (last_px_w),
        .state       (state),
        .load        (load_w),
        .capture     (capture_w),
        .adv_src     (adv_src_w),
        .adv_dst     (adv_dst_w),
        .sel_hi      (sel_hi_w),
        .req         (mem_req),
        .we          (mem_we),
        .stall       (stall_w),
        .busy        (busy),
        .done        (done)
    );

    always_comb begin
        if (state == ST_FETCH) begin
            mem_addr   = src_addr_q;
            mem_region = src_vid_q ? REGION_VIDEO : REGION_MAIN;
        end else begin
            mem_addr   = dst_addr_q;
            mem_region = dst_vid_q ? REGION_VIDEO : REGION_MAIN;
        end
        mem_wdata = pixel_w;
    end

endmodule

// File: rtl/blit_checker.sv
module blit_checker #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int PIX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic [LEN_W-1:0]  cmd_len,
    input logic              busy,
    input logic              done,
    input logic              slot_free,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_region,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [PIX_W-1:0]  mem_wdata,
    input logic [PIX_W-1:0]  key_q,
    input logic              stall_w
);
    assert_main_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_region == 1'b0) |-> slot_free);

    assert_no_key_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata != key_q));

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_w |=> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_region) && busy));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy && cmd_len == '0) |=> (done && !busy && !mem_req));

    assert_start_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy && cmd_len != '0) |=> busy);

endmodule

bind row_blitter blit_checker #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .PIX_W  (PIX_W)
) checker_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_len    (cmd_len),
    .busy       (busy),
    .done       (done),
    .slot_free  (slot_free),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_region (mem_region),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .key_q      (key_q),
    .stall_w    (stall_w)
);

// File: tb/row_blitter_tb_top.sv
module row_blitter_tb_top;
    localparam int MEM_N = 1024;

    typedef struct packed {
        logic        region;
        logic [15:0] addr;
        logic [7:0]  data;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [15:0] cmd_src = '0;
    logic        cmd_src_vid = 1'b0;
    logic [15:0] cmd_dst = '0;
    logic        cmd_dst_vid = 1'b0;
    logic [7:0]  cmd_len = '0;
    logic [7:0]  cmd_key = '0;
    logic        busy;
    logic        done;
    logic        slot_free = 1'b1;
    logic        mem_req;
    logic        mem_we;
    logic        mem_region;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [15:0] mem_rdata;

    logic [7:0]  main_mem [MEM_N];
    logic [7:0]  vid_mem  [MEM_N];
    wr_item_t    exp_q [$];
    int          total = 0;
    int          bad = 0;
    int          req_count = 0;
    int          cycles = 0;
    logic        slot_mode = 1'b0;
    logic        slot_hold_low = 1'b0;
    logic [7:0]  lfsr = 8'h5b;

    always #4 clk = ~clk;

    row_blitter dut_i (
        .clk (clk), .rst_n (rst_n), .cmd_start (cmd_start),
        .cmd_src (cmd_src), .cmd_src_vid (cmd_src_vid),
        .cmd_dst (cmd_dst), .cmd_dst_vid (cmd_dst_vid),
        .cmd_len (cmd_len), .cmd_key (cmd_key),
        .busy (busy), .done (done), .slot_free (slot_free),
        .mem_req (mem_req), .mem_we (mem_we), .mem_region (mem_region),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
    );

    function automatic logic [7:0] rd_byte(input logic vid, input logic [15:0] a);
        return vid ? vid_mem[a[9:0]] : main_mem[a[9:0]];
    endfunction

    always_comb begin
        mem_rdata = {rd_byte(mem_region, mem_addr + 16'd1), rd_byte(mem_region, mem_addr)};
    end

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            if (mem_region) vid_mem[mem_addr[9:0]] <= mem_wdata;
            else            main_mem[mem_addr[9:0]] <= mem_wdata;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // slot pattern generator
    always @(posedge clk) begin
        #2;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (slot_hold_low)  slot_free <= 1'b0;
        else if (slot_mode) slot_free <= lfsr[0] & lfsr[2];
        else                slot_free <= 1'b1;
    end

    // monitor: compares writes against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            req_count++;
            if (mem_region == 1'b0) check(slot_free, "R6 main access without slot", 0, 1);
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10/R3 unexpected write", int'(mem_addr), -1);
                end else begin
                    wr_item_t e;
                    e = exp_q.pop_front();
                    check(mem_region == e.region, "R3 write region", int'(mem_region), int'(e.region));
                    check(mem_addr == e.addr, "R3 write address", int'(mem_addr), int'(e.addr));
                    check(mem_wdata == e.data, "R3 write data", int'(mem_wdata), int'(e.data));
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_job(input logic [15:0] src, input logic sv, input logic [15:0] dst,
                           input logic dv, input logic [7:0] len, input logic [7:0] key,
                           input logic pace, input logic poke);
        logic [7:0] keep [256];
        int busy_n = 0;
        int req0;
        int expc;
        for (int i = 0; i < int'(len); i++) begin
            logic [7:0] b;
            wr_item_t it;
            b = rd_byte(sv, src + 16'(i));
            keep[i] = rd_byte(dv, dst + 16'(i));
            if (b != key) begin
                it.region = dv; it.addr = dst + 16'(i); it.data = b;
                exp_q.push_back(it);
            end
        end
        req0 = req_count;
        @(posedge clk); #2;
        cmd_src = src; cmd_src_vid = sv; cmd_dst = dst; cmd_dst_vid = dv;
        cmd_len = len; cmd_key = key; cmd_start = 1'b1;
        @(posedge clk); #2;
        cmd_start = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (poke && n == 2) begin
                cmd_dst = 16'h0300; cmd_len = 8'd5; cmd_key = 8'hff; cmd_start = 1'b1;
            end else begin
                cmd_start = 1'b0;
            end
            if (busy) busy_n++;
            if (done) break;
        end
        check(done == 1'b1 && busy == 1'b0, "R8 done with busy low", int'(done), 1);
        expc = 3 * (int'(len) / 2) + 2 * (int'(len) % 2);
        if (pace) check(busy_n == expc, "R5 busy cycles", busy_n, expc);
        else      check(busy_n >= expc, "R7 stalled job length", busy_n, expc);
        check(exp_q.size() == 0, "R3 missing writes", exp_q.size(), 0);
        if (len == 8'd0) check(req_count == req0, "R9 zero length accesses", req_count - req0, 0);
        for (int i = 0; i < int'(len); i++) begin
            if (rd_byte(sv, src + 16'(i)) == key)
                check(rd_byte(dv, dst + 16'(i)) == keep[i], "R4 transparent kept",
                      int'(rd_byte(dv, dst + 16'(i))), int'(keep[i]));
        end
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", int'(done), 0);
        repeat (8) @(negedge clk);
        check(busy == 1'b0, "R10 no second job", int'(busy), 0);
        while (exp_q.size() != 0) void'(exp_q.pop_front());
    endtask

    initial begin
        for (int i = 0; i < MEM_N; i++) begin
            main_mem[i] = 8'((i * 7 + 3) & 255);
            vid_mem[i]  = 8'(i) ^ 8'h5a;
        end
        main_mem[16'h0042] = main_mem[16'h0040];
        for (int i = 0; i < 4; i++) vid_mem[16'h0100 + i] = 8'h77;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R1 reset outputs",
              int'({busy, done, mem_req}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2 R3 R4 R5 R11-style: main to video, even length, some transparent
        run_job(16'h0040, 1'b0, 16'h0200, 1'b1, 8'd8, main_mem[16'h0040], 1'b1, 1'b0);
        // video to main, odd length (R5 odd tail)
        run_job(16'h0010, 1'b1, 16'h0180, 1'b0, 8'd7, 8'hff, 1'b1, 1'b0);
        // single pixel
        run_job(16'h0020, 1'b0, 16'h0220, 1'b1, 8'd1, 8'h00, 1'b1, 1'b0);
        // R9 zero length
        run_job(16'h0020, 1'b0, 16'h0240, 1'b1, 8'd0, 8'h00, 1'b1, 1'b0);
        // R4 all transparent, pace unchanged
        run_job(16'h0100, 1'b1, 16'h0260, 1'b0, 8'd4, 8'h77, 1'b1, 1'b0);
        // R6 R7 main to main with slot withdrawn in a pattern
        slot_mode = 1'b1;
        run_job(16'h0080, 1'b0, 16'h0280, 1'b0, 8'd13, main_mem[16'h0083], 1'b0, 1'b0);
        run_job(16'h0090, 1'b0, 16'h02a0, 1'b1, 8'd10, 8'hff, 1'b0, 1'b0);
        slot_mode = 1'b0;
        // R6 video to video at full pace with slot held low
        slot_hold_low = 1'b1;
        repeat (2) @(posedge clk);
        run_job(16'h0030, 1'b1, 16'h0300, 1'b1, 8'd6, 8'hff, 1'b1, 1'b0);
        slot_hold_low = 1'b0;
        repeat (2) @(posedge clk);
        // R10 start while busy ignored
        run_job(16'h0050, 1'b0, 16'h0320, 1'b1, 8'd9, 8'hff, 1'b1, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule